// File: doc/BRIEF.md
# TRNG Control Register File

This block is the configuration and readout register file that sits in front of a true-random-number generator's self-test logic. Software programs the statistical-test limits and the entropy sampling delay while a program-mode bit is set, then clears that bit to let the generator run. Three of the word offsets are shared. While program mode is set, they hold limits that software has written. While run mode is active, a read at the same offset returns a live measurement that the test logic supplies on input ports.

Writes are checked before any register changes. A sampling-mode value of 3 is not a legal encoding, and an entropy delay outside its allowed window is also refused. Either case drops the whole write and sets a sticky error flag. Limit and seed writes made in run mode are ignored without raising the flag. Reads and writes use separate address ports, so one of each can happen in the same cycle. Read data is registered and appears one cycle after the request.

Top module: `trng_ctrl_regs`

## Requirements
- R1: After a synchronous reset, program mode is set, the sample mode is 0, the entropy delay is 3200, the error flag is clear, and every limit register reads 0. The control word at offset 0 then reads 0x00010000.
- R2: A write to offset 0 sets program mode from bit 16 and the sample mode from bits 1:0. The sample-mode encodings are: 0 = von Neumann data for both shifter and checker, 1 = raw data for both, 2 = von Neumann data for the shifter and raw data for the checker, 3 = illegal. A write carrying mode 3 changes neither field and sets the error flag.
- R3: Offset 2 reads the poker maximum in program mode and the poker square measurement in run mode. Offset 4 reads the sparse-bit limit in program mode and the total-samples count in run mode. Offset 6 reads the frequency maximum in program mode and the live frequency count in run mode.
- R4: In run mode, writes to offsets 1 through 6 change no register and raise no error.
- R5: Offset 3 holds the entropy delay in bits 31:16 and the sample size in bits 15:0. A program-mode write is accepted only when the delay lies between 3200 and 12800, both limits included. Any other delay leaves the register unchanged and sets the error flag.
- R6: At offset 6, bits 19:0 hold the frequency-count maximum and bit 20 turns off the maximum check. Both are driven on outputs and read back at their bit positions in program mode.
- R7: The error flag reads at bit 8 of offset 0 and stays set until a legal write to offset 0 has bit 8 set. When a write both clears and sets the flag, the set wins.
- R8: Read data and rd_valid appear one cycle after rd_en. A read in the same cycle as a write returns the contents and the mode from before that write.
- R9: The poker range (offset 1), the frequency minimum (offset 5) and the seed word (offset 3) read back their stored values in both modes.
- R10: Offset 7 reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write word offset |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read word offset |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | rdata valid, one cycle after rd_en |
| meas_poker_sq | input | PKR_W | Poker square measurement |
| meas_total_samp | input | TOT_W | Total samples count |
| meas_frq_cnt | input | FRQ_W | Live frequency count |
| cfg_prog_mode | output | 1 | Program mode active |
| cfg_samp_mode | output | 2 | Sample mode |
| cfg_ent_dly | output | 16 | Entropy delay |
| cfg_samp_size | output | 16 | Sample size |
| cfg_pkr_range | output | RNG_W | Poker range limit |
| cfg_pkr_max | output | PKR_W | Poker maximum limit |
| cfg_sparse_lim | output | SPB_W | Sparse-bit limit |
| cfg_frq_min | output | FRQ_W | Frequency minimum limit |
| cfg_frq_max | output | FRQ_W | Frequency maximum limit |
| cfg_frq_chk_off | output | 1 | Frequency maximum check disabled |
| cfg_err | output | 1 | Sticky rejected-write flag |

## Verification
A read and a write can happen in the same cycle. The case that matters most is a control write that flips the mode while a shared offset is being read. The bench issues both in one cycle, once from program to run mode and once back. It expects the read to follow the old mode, so it sees the stored limit in one case and the measurement in the other. A write and a read of the same limit offset in one cycle must likewise return the old value, and the next read must return the new one.

// File: rtl/trng_cfg_pkg.sv
package trng_cfg_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL      = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_PKR_RANGE = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_PKR_ALIAS = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_SEED      = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_SPB_ALIAS = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_FRQ_MIN   = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_FRQ_ALIAS = 3'd6;

  // bit positions that software decodes
  localparam int PROG_BIT    = 16;
  localparam int ERR_BIT     = 8;
  localparam int FRQ_OFF_BIT = 20;
  localparam int DLY_LSB     = 16;
  localparam int DLY_W       = 16;
  localparam int SSZ_W       = 16;

  // index of each plain limit register in the write-enable vector
  localparam int LIM_PRNG = 0;
  localparam int LIM_PMAX = 1;
  localparam int LIM_SPB  = 2;
  localparam int LIM_FMIN = 3;
  localparam int LIM_FMAX = 4;
  localparam int NUM_LIM  = 5;

  typedef enum logic [1:0] {
    SMP_VN_BOTH  = 2'd0,
    SMP_RAW_BOTH = 2'd1,
    SMP_VN_SHIFT = 2'd2,
    SMP_ILLEGAL  = 2'd3
  } samp_mode_e;

  function automatic logic [ADDR_W-1:0] lim_ofs(input int idx);
    case (idx)
      LIM_PRNG: lim_ofs = OFS_PKR_RANGE;
      LIM_PMAX: lim_ofs = OFS_PKR_ALIAS;
      LIM_SPB:  lim_ofs = OFS_SPB_ALIAS;
      LIM_FMIN: lim_ofs = OFS_FRQ_MIN;
      default:  lim_ofs = OFS_FRQ_ALIAS;
    endcase
  endfunction
endpackage

// File: rtl/trng_cfg_wr_check.sv
module trng_cfg_wr_check
  import trng_cfg_pkg::*;
#(
  parameter int EDLY_MIN = 3200,
  parameter int EDLY_MAX = 12800
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        ctl_mode,
  input  logic              ctl_clr,
  input  logic [DLY_W-1:0]  dly,
  input  logic              prog,
  output logic              ctrl_we,
  output logic              seed_we,
  output logic [NUM_LIM-1:0] lim_we,
  output logic              err_set,
  output logic              err_clr
);
  localparam logic [DLY_W-1:0] DLY_LO = DLY_W'(EDLY_MIN);
  localparam logic [DLY_W-1:0] DLY_HI = DLY_W'(EDLY_MAX);

  logic hit_ctrl, hit_seed, mode_bad, dly_bad;

  always_comb begin
    hit_ctrl = wr_en && (wr_addr == OFS_CTRL);
    hit_seed = wr_en && prog && (wr_addr == OFS_SEED);
    mode_bad = hit_ctrl && (samp_mode_e'(ctl_mode) == SMP_ILLEGAL);
    dly_bad  = hit_seed && ((dly < DLY_LO) || (dly > DLY_HI));
    ctrl_we  = hit_ctrl && !mode_bad;
    seed_we  = hit_seed && !dly_bad;
    err_set  = mode_bad || dly_bad;
    err_clr  = ctrl_we && ctl_clr;
  end

  for (genvar i = 0; i < NUM_LIM; i++) begin : g_lim_we
    assign lim_we[i] = wr_en && prog && (wr_addr == lim_ofs(i));
  end
endmodule

// File: rtl/trng_cfg_field.sv
module trng_cfg_field #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= d;
  end
endmodule

// File: rtl/trng_cfg_core.sv
module trng_cfg_core
  import trng_cfg_pkg::*;
#(
  parameter int EDLY_RST = 3200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic             seed_we,
  input  logic             err_set,
  input  logic             err_clr,
  input  logic             wd_prog,
  input  logic [1:0]       wd_mode,
  input  logic [DLY_W-1:0] wd_dly,
  input  logic [SSZ_W-1:0] wd_ssz,
  output logic             prog_q,
  output samp_mode_e       mode_q,
  output logic             err_q,
  output logic [DLY_W-1:0] dly_q,
  output logic [SSZ_W-1:0] ssz_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q <= 1'b1;
      mode_q <= SMP_VN_BOTH;
    end else if (ctrl_we) begin
      prog_q <= wd_prog;
      mode_q <= samp_mode_e'(wd_mode);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q <= DLY_W'(EDLY_RST);
      ssz_q <= '0;
    end else if (seed_we) begin
      dly_q <= wd_dly;
      ssz_q <= wd_ssz;
    end
  end

  // set has priority over clear
  always_ff @(posedge clk) begin
    if (rst)          err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end
endmodule

// File: rtl/trng_cfg_rdmux.sv
module trng_cfg_rdmux
  import trng_cfg_pkg::*;
#(
  parameter int RNG_W = 16,
  parameter int PKR_W = 24,
  parameter int SPB_W = 16,
  parameter int TOT_W = 24,
  parameter int FRQ_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              prog,
  input  samp_mode_e        mode,
  input  logic              err,
  input  logic [DLY_W-1:0]  dly,
  input  logic [SSZ_W-1:0]  ssz,
  input  logic [RNG_W-1:0]  pkr_range,
  input  logic [PKR_W-1:0]  pkr_max,
  input  logic [SPB_W-1:0]  spb_lim,
  input  logic [FRQ_W-1:0]  frq_min,
  input  logic [FRQ_W-1:0]  frq_max,
  input  logic              frq_off,
  input  logic [PKR_W-1:0]  m_pkr_sq,
  input  logic [TOT_W-1:0]  m_total,
  input  logic [FRQ_W-1:0]  m_frq,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] ctrl_word, frq_word;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[PROG_BIT] = prog;
    ctrl_word[ERR_BIT]  = err;
    ctrl_word[1:0]      = mode;
    frq_word = DATA_W'(frq_max);
    frq_word[FRQ_OFF_BIT] = frq_off;
    case (rd_addr)
      OFS_CTRL:      sel = ctrl_word;
      OFS_PKR_RANGE: sel = DATA_W'(pkr_range);
      OFS_PKR_ALIAS: sel = prog ? DATA_W'(pkr_max) : DATA_W'(m_pkr_sq);
      OFS_SEED:      sel = {dly, ssz};
      OFS_SPB_ALIAS: sel = prog ? DATA_W'(spb_lim) : DATA_W'(m_total);
      OFS_FRQ_MIN:   sel = DATA_W'(frq_min);
      OFS_FRQ_ALIAS: sel = prog ? frq_word : DATA_W'(m_frq);
      default:       sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= sel;
    end
  end
endmodule

// File: rtl/trng_ctrl_regs.sv
module trng_ctrl_regs
  import trng_cfg_pkg::*;
#(
  parameter int RNG_W    = 16,
  parameter int PKR_W    = 24,
  parameter int SPB_W    = 16,
  parameter int TOT_W    = 24,
  parameter int FRQ_W    = 20,
  parameter int EDLY_MIN = 3200,
  parameter int EDLY_MAX = 12800,
  parameter int EDLY_RST = 3200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wdata,
  input  logic              rd_en,
  input  logic [2:0]        rd_addr,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  input  logic [PKR_W-1:0]  meas_poker_sq,
  input  logic [TOT_W-1:0]  meas_total_samp,
  input  logic [FRQ_W-1:0]  meas_frq_cnt,
  output logic              cfg_prog_mode,
  output logic [1:0]        cfg_samp_mode,
  output logic [15:0]       cfg_ent_dly,
  output logic [15:0]       cfg_samp_size,
  output logic [RNG_W-1:0]  cfg_pkr_range,
  output logic [PKR_W-1:0]  cfg_pkr_max,
  output logic [SPB_W-1:0]  cfg_sparse_lim,
  output logic [FRQ_W-1:0]  cfg_frq_min,
  output logic [FRQ_W-1:0]  cfg_frq_max,
  output logic              cfg_frq_chk_off,
  output logic              cfg_err
);
  localparam int FMX_W = FRQ_W + 1;

  logic               ctrl_we, seed_we, err_set, err_clr;
  logic [NUM_LIM-1:0] lim_we;
  samp_mode_e         mode_q;
  logic [FMX_W-1:0]   fmax_q;

  trng_cfg_wr_check #(.EDLY_MIN(EDLY_MIN), .EDLY_MAX(EDLY_MAX)) u_wr_check (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .ctl_mode (wdata[1:0]),
    .ctl_clr  (wdata[ERR_BIT]),
    .dly      (wdata[DLY_LSB +: DLY_W]),
    .prog     (cfg_prog_mode),
    .ctrl_we  (ctrl_we),
    .seed_we  (seed_we),
    .lim_we   (lim_we),
    .err_set  (err_set),
    .err_clr  (err_clr)
  );

  trng_cfg_core #(.EDLY_RST(EDLY_RST)) u_core (
    .clk     (clk),
    .rst     (rst),
    .ctrl_we (ctrl_we),
    .seed_we (seed_we),
    .err_set (err_set),
    .err_clr (err_clr),
    .wd_prog (wdata[PROG_BIT]),
    .wd_mode (wdata[1:0]),
    .wd_dly  (wdata[DLY_LSB +: DLY_W]),
    .wd_ssz  (wdata[SSZ_W-1:0]),
    .prog_q  (cfg_prog_mode),
    .mode_q  (mode_q),
    .err_q   (cfg_err),
    .dly_q   (cfg_ent_dly),
    .ssz_q   (cfg_samp_size)
  );

  assign cfg_samp_mode = mode_q;

  trng_cfg_field #(.W(RNG_W)) u_f_prng (
    .clk(clk), .rst(rst), .we(lim_we[LIM_PRNG]),
    .d(wdata[RNG_W-1:0]), .q(cfg_pkr_range));

  trng_cfg_field #(.W(PKR_W)) u_f_pmax (
    .clk(clk), .rst(rst), .we(lim_we[LIM_PMAX]),
    .d(wdata[PKR_W-1:0]), .q(cfg_pkr_max));

  trng_cfg_field #(.W(SPB_W)) u_f_spb (
    .clk(clk), .rst(rst), .we(lim_we[LIM_SPB]),
    .d(wdata[SPB_W-1:0]), .q(cfg_sparse_lim));

  trng_cfg_field #(.W(FRQ_W)) u_f_fmin (
    .clk(clk), .rst(rst), .we(lim_we[LIM_FMIN]),
    .d(wdata[FRQ_W-1:0]), .q(cfg_frq_min));

  trng_cfg_field #(.W(FMX_W)) u_f_fmax (
    .clk(clk), .rst(rst), .we(lim_we[LIM_FMAX]),
    .d({wdata[FRQ_OFF_BIT], wdata[FRQ_W-1:0]}), .q(fmax_q));

  assign cfg_frq_max     = fmax_q[FRQ_W-1:0];
  assign cfg_frq_chk_off = fmax_q[FRQ_W];

  trng_cfg_rdmux #(
    .RNG_W(RNG_W), .PKR_W(PKR_W), .SPB_W(SPB_W), .TOT_W(TOT_W), .FRQ_W(FRQ_W)
  ) u_rdmux (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .prog      (cfg_prog_mode),
    .mode      (mode_q),
    .err       (cfg_err),
    .dly       (cfg_ent_dly),
    .ssz       (cfg_samp_size),
    .pkr_range (cfg_pkr_range),
    .pkr_max   (cfg_pkr_max),
    .spb_lim   (cfg_sparse_lim),
    .frq_min   (cfg_frq_min),
    .frq_max   (cfg_frq_max),
    .frq_off   (cfg_frq_chk_off),
    .m_pkr_sq  (meas_poker_sq),
    .m_total   (meas_total_samp),
    .m_frq     (meas_frq_cnt),
    .rdata     (rdata),
    .rd_valid  (rd_valid)
  );
endmodule

// File: rtl/trng_ctrl_regs_chk.sv
module trng_ctrl_regs_chk #(
  parameter int PKR_W    = 24,
  parameter int EDLY_MIN = 3200,
  parameter int EDLY_MAX = 12800
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [1:0]       ctl_mode,
  input logic             ctl_clr,
  input logic             rd_en,
  input logic [2:0]       rd_addr,
  input logic [31:0]      rdata,
  input logic             rd_valid,
  input logic [PKR_W-1:0] meas_poker_sq,
  input logic             cfg_prog_mode,
  input logic [1:0]       cfg_samp_mode,
  input logic [15:0]      cfg_ent_dly,
  input logic [PKR_W-1:0] cfg_pkr_max,
  input logic             cfg_err
);
  localparam logic [15:0] DLY_LO = 16'(EDLY_MIN);
  localparam logic [15:0] DLY_HI = 16'(EDLY_MAX);

  p_bad_mode_rejected_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd0 && ctl_mode == 2'b11)
    |=> (cfg_err && $stable(cfg_samp_mode) && $stable(cfg_prog_mode)));

  p_mode_legal_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_samp_mode != 2'b11);

  p_alias_run_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == 3'd2 && !cfg_prog_mode)
    |=> (rdata == 32'($past(meas_poker_sq))));

  p_run_write_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd2 && !cfg_prog_mode) |=> $stable(cfg_pkr_max));

  p_dly_in_window_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_ent_dly >= DLY_LO) && (cfg_ent_dly <= DLY_HI));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && !(wr_en && wr_addr == 3'd0 && ctl_clr)) |=> cfg_err);

  p_rd_latency_r8: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

bind trng_ctrl_regs trng_ctrl_regs_chk #(
  .PKR_W(PKR_W), .EDLY_MIN(EDLY_MIN), .EDLY_MAX(EDLY_MAX)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .ctl_mode      (wdata[1:0]),
  .ctl_clr       (wdata[8]),
  .rd_en         (rd_en),
  .rd_addr       (rd_addr),
  .rdata         (rdata),
  .rd_valid      (rd_valid),
  .meas_poker_sq (meas_poker_sq),
  .cfg_prog_mode (cfg_prog_mode),
  .cfg_samp_mode (cfg_samp_mode),
  .cfg_ent_dly   (cfg_ent_dly),
  .cfg_pkr_max   (cfg_pkr_max),
  .cfg_err       (cfg_err)
);

// File: tb/trng_ctrl_regs_bench.sv
`timescale 1ns/1ps
module trng_ctrl_regs_bench;
  localparam int RNG_W = 16, PKR_W = 24, SPB_W = 16, TOT_W = 24, FRQ_W = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rd_valid;
  logic [PKR_W-1:0] meas_poker_sq = '0;
  logic [TOT_W-1:0] meas_total_samp = '0;
  logic [FRQ_W-1:0] meas_frq_cnt = '0;
  logic cfg_prog_mode, cfg_frq_chk_off, cfg_err;
  logic [1:0] cfg_samp_mode;
  logic [15:0] cfg_ent_dly, cfg_samp_size;
  logic [RNG_W-1:0] cfg_pkr_range;
  logic [PKR_W-1:0] cfg_pkr_max;
  logic [SPB_W-1:0] cfg_sparse_lim;
  logic [FRQ_W-1:0] cfg_frq_min, cfg_frq_max;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  trng_ctrl_regs u_trng_ctrl_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rdata(rdata), .rd_valid(rd_valid),
    .meas_poker_sq(meas_poker_sq), .meas_total_samp(meas_total_samp),
    .meas_frq_cnt(meas_frq_cnt), .cfg_prog_mode(cfg_prog_mode),
    .cfg_samp_mode(cfg_samp_mode), .cfg_ent_dly(cfg_ent_dly),
    .cfg_samp_size(cfg_samp_size), .cfg_pkr_range(cfg_pkr_range),
    .cfg_pkr_max(cfg_pkr_max), .cfg_sparse_lim(cfg_sparse_lim),
    .cfg_frq_min(cfg_frq_min), .cfg_frq_max(cfg_frq_max),
    .cfg_frq_chk_off(cfg_frq_chk_off), .cfg_err(cfg_err)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // monitor: pops the scoreboard as read data comes back
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R8: read data 0x%08h with no expected entry", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wrrd(input logic [2:0] wa, input logic [31:0] d,
                      input logic [2:0] ra, input logic [31:0] exp, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = wa; wdata = d;
    rd_en = 1'b1; rd_addr = ra;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 prog", 32'(cfg_prog_mode), 32'd1);
    check("R1 mode", 32'(cfg_samp_mode), 32'd0);
    check("R1 dly", 32'(cfg_ent_dly), 32'd3200);
    check("R1 err", 32'(cfg_err), 32'd0);
    rd(3'd0, 32'h0001_0000, "R1 ctrl word");
    rd(3'd2, 32'h0, "R1 poker max reset");

    // program limits
    wr(3'd2, 32'h0012_3456);
    wr(3'd4, 32'h0000_BEEF);
    wr(3'd6, 32'h001A_BCDE);
    wr(3'd1, 32'h0000_5555);
    wr(3'd5, 32'h0000_0321);
    check("R6 frq max", 32'(cfg_frq_max), 32'h000A_BCDE);
    check("R6 chk off", 32'(cfg_frq_chk_off), 32'd1);
    rd(3'd2, 32'h0012_3456, "R3 prog poker");
    rd(3'd4, 32'h0000_BEEF, "R3 prog sparse");
    rd(3'd6, 32'h001A_BCDE, "R6 prog frq readback");

    // R5 entropy delay window
    wr(3'd3, {16'd12800, 16'h0100});
    check("R5 dly max", 32'(cfg_ent_dly), 32'd12800);
    check("R5 no err", 32'(cfg_err), 32'd0);
    rd(3'd3, 32'h3200_0100, "R5 seed readback");
    wr(3'd3, {16'd12801, 16'h0200});
    check("R5 reject hi", 32'(cfg_ent_dly), 32'd12800);
    check("R5 ssz kept", 32'(cfg_samp_size), 32'h0100);
    check("R5 err set", 32'(cfg_err), 32'd1);
    wr(3'd0, 32'h0001_0100);
    check("R7 clear", 32'(cfg_err), 32'd0);
    wr(3'd3, {16'd3199, 16'h0000});
    check("R5 reject lo", 32'(cfg_ent_dly), 32'd12800);
    wr(3'd3, {16'd3200, 16'h0040});
    check("R5 dly min", 32'(cfg_ent_dly), 32'd3200);
    check("R7 sticky", 32'(cfg_err), 32'd1);
    rd(3'd0, 32'h0001_0100, "R7 err in ctrl word");

    // R2 sample mode
    wr(3'd0, 32'h0001_0100);
    wr(3'd0, 32'h0001_0003);
    check("R2 illegal mode kept", 32'(cfg_samp_mode), 32'd0);
    check("R2 illegal sets err", 32'(cfg_err), 32'd1);
    wr(3'd0, 32'h0001_0102);
    check("R2 mode 2", 32'(cfg_samp_mode), 32'd2);
    check("R7 clr with write", 32'(cfg_err), 32'd0);
    wr(3'd0, 32'h0000_0103);
    check("R7 set beats clear", 32'(cfg_err), 32'd1);
    check("R2 prog kept", 32'(cfg_prog_mode), 32'd1);
    wr(3'd0, 32'h0001_0102);

    // R8 mode switch with concurrent shared read
    meas_poker_sq = 24'hAB_CDEF;
    meas_total_samp = 24'h05_4321;
    meas_frq_cnt = 20'h0_F0F0;
    wrrd(3'd0, 32'h0000_0002, 3'd2, 32'h0012_3456, "R8 old mode on switch to run");
    check("R2 run mode", 32'(cfg_prog_mode), 32'd0);
    rd(3'd2, 32'h00AB_CDEF, "R3 run poker sq");
    rd(3'd4, 32'h0005_4321, "R3 run total");
    rd(3'd6, 32'h0000_F0F0, "R3 run frq");
    rd(3'd1, 32'h0000_5555, "R9 range run");
    rd(3'd5, 32'h0000_0321, "R9 frq min run");
    rd(3'd3, 32'h0C80_0040, "R9 seed run");

    // R4 run-mode writes ignored
    wr(3'd2, 32'h0011_1111);
    check("R4 pkr max kept", 32'(cfg_pkr_max), 32'h0012_3456);
    wr(3'd1, 32'h0000_7777);
    rd(3'd1, 32'h0000_5555, "R4 range kept");
    wr(3'd3, {16'd5000, 16'h0000});
    check("R4 dly kept", 32'(cfg_ent_dly), 32'd3200);
    check("R4 no err", 32'(cfg_err), 32'd0);
    wr(3'd6, 32'h0);
    check("R4 chk off kept", 32'(cfg_frq_chk_off), 32'd1);
    rd(3'd0, 32'h0000_0002, "R4 ctrl word run");

    // R10 unmapped offset
    rd(3'd7, 32'h0, "R10 read zero");
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd0, 32'h0000_0002, "R10 ctrl unchanged");
    check("R10 pkr max unchanged", 32'(cfg_pkr_max), 32'h0012_3456);

    // R8 back to program mode with concurrent shared read
    wrrd(3'd0, 32'h0001_0002, 3'd6, 32'h0000_F0F0, "R8 old mode on switch to prog");
    rd(3'd6, 32'h001A_BCDE, "R3 prog frq again");
    wrrd(3'd1, 32'h0000_6666, 3'd1, 32'h0000_5555, "R8 read before write");
    rd(3'd1, 32'h0000_6666, "R8 read after write");
    rd(3'd2, 32'h0012_3456, "R3 prog ignores meas");

    repeat (4) @(negedge clk);
    check("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule